// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a memory-mapped watchdog for a slow functional clock (nominally around 32 kHz) that is programmed from a faster bus clock. An up-counter in the functional domain advances on prescaled ticks. When it wraps past its all-ones value while running, it raises a reset request for a fixed number of functional cycles and restarts from a programmable load value. Software keeps the system alive by writing new values to a trigger register. Each such write reloads the counter, but only when the value differs from the previous trigger value.

The timer starts only after a two-word start key and stops only after a two-word stop key, both written to the key register. Every write to the control, load, trigger and key registers is posted. The bus side keeps the written value and raises a per-register pending flag. A toggle handshake carries the value into the functional domain, and the flag drops once the acknowledge returns. A write that targets a register whose flag is still set is dropped. Software therefore polls the pending status before it writes the same register again.

The register port is a plain single-cycle strobe interface with no stream handshake. A write is taken on the bus clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one bus clock after `bus_rd`.

Top module: `wdg_top`

## Requirements
- R1: After reset the timer is stopped and `wdt_rst` is low. The pending status reads 0. The revision register (offset 0x00) returns the REV parameter in bits 7:0 and zero above.
- R2: Writing 0xBBBB and then 0x4444 to the key register (offset 0x14, low 16 bits compared) starts the counter. The first word alone, with no second write, does not start it.
- R3: Writing 0xAAAA and then 0x5555 to the key register stops the counter. While stopped, the counter holds its value and no further reset pulses occur.
- R4: When the first key word of a pair is followed by any other word, the sequence is abandoned and the run state is unchanged. A later lone second word has no effect.
- R5: The pending status register (offset 0x08) has bit 0 for control (0x04), bit 2 for load (0x0C), bit 3 for trigger (0x10) and bit 4 for key (0x14). A bit reads 1 right after a write to its register and returns to 0 once the value has reached the functional domain.
- R6: A write to a register whose pending bit is set is discarded. Reading back the control register then returns the earlier value.
- R7: A trigger write whose value differs from the previous trigger value reloads the counter from the load value. A trigger write that repeats the previous value does not reload it.
- R8: While running, the counter increments once per tick. On the tick at 0xFFFFFFFF it reloads from the load value and drives `wdt_rst` high for RST_CYCLES functional cycles. With a constant load value L, successive pulses start (2^32 - L) ticks apart.
- R9: Control bit 5 enables the prescaler, and control bits 4:2 hold PTV. When the prescaler is enabled, a tick occurs every 2^PTV functional cycles. When it is disabled, a tick occurs on every functional cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for register access |
| func_clk | input | 1 | Slow functional clock for counter and prescaler |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, sampled on bus_clk |
| bus_rd | input | 1 | Read strobe, sampled on bus_clk |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one bus_clk after bus_rd |
| wdt_rst | output | 1 | Reset request, func_clk domain, high for RST_CYCLES cycles per wrap |

## Verification
The start logic is tried with three key patterns. A mismatched second word shows that a broken pair leaves the timer stopped. A lone first word followed by a long idle gap shows that the armed state waits. A correct pair shows that the counter starts. Refresh is tried with a stream of distinct trigger values, which must hold off every pulse, and with a repeated value, which must let pulses arrive at exactly the unrefreshed interval. The pulse interval is measured with the prescaler both off and on, and the two results separate the tick rates. A back-to-back pair of control writes separates "second write dropped" from "last write wins", both in the read-back value and in the resulting interval.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W       = 8;
  localparam int DW           = 32;
  localparam int NREG         = 4;
  localparam int KEY_W        = 16;
  localparam int PTV_W        = 3;
  localparam int CTRL_PTV_LSB = 2;
  localparam int CTRL_PRE_BIT = 5;
  localparam int CTRL_W       = 6;

  localparam logic [ADDR_W-1:0] OFF_REV  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PEND = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_LOAD = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_TRIG = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_KEY  = 8'h14;

  localparam logic [KEY_W-1:0] KEY_ON_A  = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_ON_B  = 16'h4444;
  localparam logic [KEY_W-1:0] KEY_OFF_A = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OFF_B = 16'h5555;

  typedef enum logic [1:0] {
    RI_CTRL = 2'd0,
    RI_LOAD = 2'd1,
    RI_TRIG = 2'd2,
    RI_KEY  = 2'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    KS_IDLE      = 2'd0,
    KS_ON_ARMED  = 2'd1,
    KS_OFF_ARMED = 2'd2
  } key_state_e;

  function automatic logic [ADDR_W-1:0] reg_offset(input int idx);
    case (idx)
      0:       return OFF_CTRL;
      1:       return OFF_LOAD;
      2:       return OFF_TRIG;
      default: return OFF_KEY;
    endcase
  endfunction

  function automatic int pend_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 2;
      2:       return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/wdg_post.sv
module wdg_post #(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         bclk,
  input  logic         fclk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] shadow_o,
  output logic         pend_o,
  output logic [W-1:0] fdata_o,
  output logic         fupd_o
);
  // bus side
  logic                   req_t;
  logic                   pend_q;
  logic [W-1:0]           hold_q;
  logic [SYNC_STAGES-1:0] ack_sync;
  // functional side
  logic [SYNC_STAGES-1:0] req_sync;
  logic                   ack_t;
  logic [W-1:0]           fdata_q;
  logic                   fupd_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      req_t    <= 1'b0;
      pend_q   <= 1'b0;
      hold_q   <= '0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_STAGES-2:0], ack_t};
      if (wr_i && !pend_q) begin
        hold_q <= wdata_i;
        req_t  <= ~req_t;
        pend_q <= 1'b1;
      end else if (pend_q && (ack_sync[SYNC_STAGES-1] == req_t)) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      ack_t    <= 1'b0;
      fdata_q  <= '0;
      fupd_q   <= 1'b0;
    end else begin
      req_sync <= {req_sync[SYNC_STAGES-2:0], req_t};
      fupd_q   <= 1'b0;
      if (req_sync[SYNC_STAGES-1] != ack_t) begin
        fdata_q <= hold_q;
        ack_t   <= req_sync[SYNC_STAGES-1];
        fupd_q  <= 1'b1;
      end
    end
  end

  assign shadow_o = hold_q;
  assign pend_o   = pend_q;
  assign fdata_o  = fdata_q;
  assign fupd_o   = fupd_q;
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter logic [7:0] REV         = 8'h31,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                      bclk,
  input  logic                      fclk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  output logic [NREG-1:0]           pend_o,
  output logic [NREG-1:0][DW-1:0]   shadow_o,
  output logic [NREG-1:0][DW-1:0]   fdata_o,
  output logic [NREG-1:0]           fupd_o
);
  localparam logic [DW-1:0] CTRL_MASK = DW'((1 << CTRL_W) - 1);

  logic [NREG-1:0] wsel;
  logic [DW-1:0]   stat_w;
  logic [DW-1:0]   rdata_q;

  for (genvar g = 0; g < NREG; g++) begin : g_post
    assign wsel[g] = bus_wr && (bus_addr == reg_offset(g));
    wdg_post #(.W(DW), .SYNC_STAGES(SYNC_STAGES)) u_post (
      .bclk    (bclk),
      .fclk    (fclk),
      .rst_n   (rst_n),
      .wr_i    (wsel[g]),
      .wdata_i (bus_wdata),
      .shadow_o(shadow_o[g]),
      .pend_o  (pend_o[g]),
      .fdata_o (fdata_o[g]),
      .fupd_o  (fupd_o[g])
    );
  end

  always_comb begin
    stat_w = '0;
    for (int i = 0; i < NREG; i++) stat_w[pend_pos(i)] = pend_o[i];
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFF_REV:  rdata_q <= {{(DW-8){1'b0}}, REV};
        OFF_CTRL: rdata_q <= shadow_o[RI_CTRL] & CTRL_MASK;
        OFF_PEND: rdata_q <= stat_w;
        OFF_LOAD: rdata_q <= shadow_o[RI_LOAD];
        OFF_TRIG: rdata_q <= shadow_o[RI_TRIG];
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
  import wdg_pkg::*;
(
  input  logic             fclk,
  input  logic             rst_n,
  input  logic             key_upd_i,
  input  logic [KEY_W-1:0] key_val_i,
  output logic             run_o
);
  key_state_e state_q;
  logic       run_q;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
      run_q   <= 1'b0;
    end else if (key_upd_i) begin
      case (state_q)
        KS_IDLE: begin
          if (key_val_i == KEY_ON_A)       state_q <= KS_ON_ARMED;
          else if (key_val_i == KEY_OFF_A) state_q <= KS_OFF_ARMED;
        end
        KS_ON_ARMED: begin
          if (key_val_i == KEY_ON_B) run_q <= 1'b1;
          state_q <= KS_IDLE;
        end
        KS_OFF_ARMED: begin
          if (key_val_i == KEY_OFF_B) run_q <= 1'b0;
          state_q <= KS_IDLE;
        end
        default: state_q <= KS_IDLE;
      endcase
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic             fclk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             pre_en_i,
  input  logic [PTV_W-1:0] ptv_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             trig_upd_i,
  input  logic [CNT_W-1:0] trig_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reload_o,
  output logic             wdt_rst_o
);
  localparam int PS_W = (1 << PTV_W) - 1;
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [RC_W-1:0] RC_INIT = RC_W'(RST_CYCLES);

  logic [PS_W-1:0]  ps_q;
  logic [PS_W:0]    ps_lim;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] trig_last_q;
  logic [RC_W-1:0]  rc_q;
  logic             wrap;

  assign ps_lim   = ({{PS_W{1'b0}}, 1'b1} << ptv_i) - {{PS_W{1'b0}}, 1'b1};
  assign tick     = !pre_en_i || ({1'b0, ps_q} >= ps_lim);
  assign reload_o = trig_upd_i && (trig_val_i != trig_last_q);
  assign wrap     = run_i && tick && (cnt_q == '1) && !reload_o;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n)                  ps_q <= '0;
    else if (!run_i || !pre_en_i) ps_q <= '0;
    else if (tick)               ps_q <= '0;
    else                         ps_q <= ps_q + {{(PS_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      trig_last_q <= '0;
    end else begin
      if (trig_upd_i) trig_last_q <= trig_val_i;
      if (reload_o)                 cnt_q <= load_i;
      else if (run_i && tick) begin
        if (cnt_q == '1) cnt_q <= load_i;
        else             cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n)          rc_q <= '0;
    else if (wrap)       rc_q <= RC_INIT;
    else if (rc_q != '0) rc_q <= rc_q - {{(RC_W-1){1'b0}}, 1'b1};
  end

  assign cnt_o     = cnt_q;
  assign wdt_rst_o = (rc_q != '0);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter logic [7:0] REV         = 8'h31,
  parameter int         RST_CYCLES  = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        bus_clk,
  input  logic        func_clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst
);
  logic [NREG-1:0]         pend_w;
  logic [NREG-1:0][DW-1:0] shadow_w;
  logic [NREG-1:0][DW-1:0] fdata_w;
  logic [NREG-1:0]         fupd_w;
  logic                    run_w;
  logic [DW-1:0]           cnt_w;
  logic                    reload_w;
  logic [DW-1:0]           ctrl_shadow_w;
  logic [DW-1:0]           load_w;
  logic [KEY_W-1:0]        key_val_w;
  logic                    key_upd_w;
  logic                    unused_ok;

  wdg_regs #(.REV(REV), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .bclk     (bus_clk),
    .fclk     (func_clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pend_o   (pend_w),
    .shadow_o (shadow_w),
    .fdata_o  (fdata_w),
    .fupd_o   (fupd_w)
  );

  assign ctrl_shadow_w = shadow_w[RI_CTRL];
  assign load_w        = fdata_w[RI_LOAD];
  assign key_val_w     = fdata_w[RI_KEY][KEY_W-1:0];
  assign key_upd_w     = fupd_w[RI_KEY];

  wdg_keyseq u_keys (
    .fclk     (func_clk),
    .rst_n    (rst_n),
    .key_upd_i(key_upd_w),
    .key_val_i(key_val_w),
    .run_o    (run_w)
  );

  wdg_core #(.CNT_W(DW), .RST_CYCLES(RST_CYCLES)) u_core (
    .fclk      (func_clk),
    .rst_n     (rst_n),
    .run_i     (run_w),
    .pre_en_i  (fdata_w[RI_CTRL][CTRL_PRE_BIT]),
    .ptv_i     (fdata_w[RI_CTRL][CTRL_PTV_LSB +: PTV_W]),
    .load_i    (load_w),
    .trig_upd_i(fupd_w[RI_TRIG]),
    .trig_val_i(fdata_w[RI_TRIG]),
    .cnt_o     (cnt_w),
    .reload_o  (reload_w),
    .wdt_rst_o (wdt_rst)
  );

  assign unused_ok = ^{fupd_w[RI_CTRL], fupd_w[RI_LOAD], shadow_w[RI_KEY],
                       fdata_w[RI_KEY][DW-1:KEY_W],
                       fdata_w[RI_CTRL][DW-1:CTRL_W], fdata_w[RI_CTRL][1:0]};
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
  import wdg_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input logic             bus_clk,
  input logic             func_clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [NREG-1:0]  pend,
  input logic [DW-1:0]    ctrl_shadow,
  input logic             run,
  input logic [DW-1:0]    cnt,
  input logic             reload,
  input logic             key_upd,
  input logic [KEY_W-1:0] key_val,
  input logic             wdt_rst
);
  logic [15:0] hi_cnt;

  always_ff @(posedge func_clk or negedge rst_n) begin
    if (!rst_n)                  hi_cnt <= '0;
    else if (!wdt_rst)           hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  AST_RUN_ON_KEY: assert property (@(posedge func_clk) disable iff (!rst_n)
    $rose(run) |-> ($past(key_upd) && ($past(key_val) == KEY_ON_B))); // R2
  AST_RUN_OFF_KEY: assert property (@(posedge func_clk) disable iff (!rst_n)
    $fell(run) |-> ($past(key_upd) && ($past(key_val) == KEY_OFF_B))); // R3
  AST_STOPPED_HOLD: assert property (@(posedge func_clk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(cnt)); // R3
  AST_COUNT_STEP: assert property (@(posedge func_clk) disable iff (!rst_n)
    (run && !reload && (cnt != '1)) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + DW'(1)))); // R8
  AST_PULSE_WIDTH: assert property (@(posedge func_clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> (hi_cnt >= 16'(RST_CYCLES))); // R8
  AST_PEND_FROM_WRITE: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(pend[RI_CTRL]) |-> $past(bus_wr && (bus_addr == OFF_CTRL))); // R5
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (pend[RI_CTRL] && bus_wr && (bus_addr == OFF_CTRL)) |=> $stable(ctrl_shadow)); // R6
endmodule

bind wdg_top wdg_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .bus_clk    (bus_clk),
  .func_clk   (func_clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .pend       (pend_w),
  .ctrl_shadow(ctrl_shadow_w),
  .run        (run_w),
  .cnt        (cnt_w),
  .reload     (reload_w),
  .key_upd    (key_upd_w),
  .key_val    (key_val_w),
  .wdt_rst    (wdt_rst)
);

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
  localparam logic [7:0] REV   = 8'h31;
  localparam int         RSTC  = 4;
  localparam int         SPAN  = 64;              // 2^32 - LOAD
  localparam logic [31:0] LOAD = 32'hFFFF_FFC0;

  logic        bclk = 1'b0;
  logic        fclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst;

  always #4  bclk = ~bclk;   // 125 MHz
  always #28 fclk = ~fclk;

  wdg_top #(.REV(REV), .RST_CYCLES(RSTC)) dut (
    .bus_clk(bclk), .func_clk(fclk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard of expected reset pulses
  typedef struct { int width; int gap; } pulse_t;
  pulse_t exp_q[$];
  int fcyc = 0, pulses = 0, start_c = 0, last_start = 0;
  logic prev_rst = 1'b0;

  task automatic expect_pulse(input int gap);
    pulse_t p;
    p.width = RSTC;
    p.gap   = gap;
    exp_q.push_back(p);
  endtask

  always @(negedge fclk) begin
    fcyc++;
    if (wdt_rst && !prev_rst) start_c = fcyc;
    if (!wdt_rst && prev_rst) begin
      pulses++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected reset pulse", pulses, 0);
      end else begin
        pulse_t e;
        e = exp_q.pop_front();
        check((fcyc - start_c) == e.width, "R8 pulse width", fcyc - start_c, e.width);
        if (e.gap >= 0)
          check((start_c - last_start) == e.gap, "R8/R9 pulse interval", start_c - last_start, e.gap);
      end
      last_start = start_c;
    end
    prev_rst = wdt_rst;
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge bclk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bclk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge bclk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge bclk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_clear(input int bitpos);
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      bus_read(8'h08, s);
      if (!s[bitpos]) return;
    end
    check(1'b0, "R5 pending flag never cleared", bitpos, 0);
  endtask

  task automatic wr_wait(input logic [7:0] a, input logic [31:0] d, input int bitpos);
    bus_write(a, d);
    wait_clear(bitpos);
  endtask

  task automatic wait_pulses(input int target, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (pulses >= target) return;
      @(negedge fclk);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    int base;
    repeat (5) @(negedge bclk);
    rst_n = 1'b1;
    repeat (3) @(negedge fclk);

    // R1: reset state
    bus_read(8'h00, rd);
    check(rd == {24'd0, REV}, "R1 revision", rd, {24'd0, REV});
    bus_read(8'h08, rd);
    check(rd == 32'd0, "R1 pending after reset", rd, 0);
    check(wdt_rst == 1'b0, "R1 reset output low", wdt_rst, 0);

    // R5: load pending bit 2 sets, then clears
    bus_write(8'h0C, LOAD);
    bus_read(8'h08, rd);
    check(rd == 32'h4, "R5 load pending set", rd, 4);
    wait_clear(2);
    bus_read(8'h08, rd);
    check(rd == 32'h0, "R5 pending cleared", rd, 0);
    wr_wait(8'h04, 32'h0, 0);
    wr_wait(8'h10, 32'd1, 3);   // R7 differing value loads counter

    // R4: broken pair, then a lone second word
    wr_wait(8'h14, 32'hBBBB, 4);
    wr_wait(8'h14, 32'h1234, 4);
    wr_wait(8'h14, 32'h4444, 4);
    repeat (3 * SPAN) @(negedge fclk);
    check(pulses == 0, "R4 broken key pair keeps timer stopped", pulses, 0);

    // R2: first word alone waits, then second word starts
    wr_wait(8'h14, 32'hBBBB, 4);
    repeat (3 * SPAN) @(negedge fclk);
    check(pulses == 0, "R2 first key word alone does not start", pulses, 0);
    expect_pulse(-1);
    expect_pulse(SPAN);
    expect_pulse(SPAN);
    wr_wait(8'h14, 32'h4444, 4);
    wait_pulses(3, 6 * SPAN);
    check(pulses == 3, "R2 running after key pair", pulses, 3);

    // R7: distinct trigger values hold off the reset
    base = pulses;
    for (int i = 0; i < 8; i++) begin
      wr_wait(8'h10, 32'd100 + 32'(i), 3);
      repeat (20) @(negedge fclk);
    end
    check(pulses == base, "R7 distinct triggers refresh", pulses, base);

    // R7: repeated trigger value does not refresh
    expect_pulse(-1);
    expect_pulse(SPAN);
    for (int i = 0; i < 60 && pulses < base + 2; i++) begin
      wr_wait(8'h10, 32'd107, 3);
      repeat (10) @(negedge fclk);
    end
    check(pulses == base + 2, "R7 repeated trigger ignored", pulses, base + 2);

    // R3: stop sequence, kept alive meanwhile
    wr_wait(8'h10, 32'd200, 3);
    wr_wait(8'h14, 32'hAAAA, 4);
    wr_wait(8'h10, 32'd201, 3);
    wr_wait(8'h14, 32'h5555, 4);
    base = pulses;
    repeat (5 * SPAN) @(negedge fclk);
    check(pulses == base, "R3 stopped, no pulses", pulses, base);

    // R6: back-to-back control writes, second dropped
    @(negedge bclk);
    bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h24;
    @(negedge bclk);
    bus_wdata = 32'h28;
    @(negedge bclk);
    bus_wr = 1'b0;
    bus_read(8'h08, rd);
    check(rd[0] == 1'b1, "R5 control pending bit 0", rd[0], 1);
    wait_clear(0);
    bus_read(8'h04, rd);
    check(rd == 32'h24, "R6 write while pending dropped", rd, 32'h24);

    // R9: prescaler on, PTV=1 doubles the interval
    wr_wait(8'h10, 32'd300, 3);
    expect_pulse(-1);
    expect_pulse(2 * SPAN);
    base = pulses;
    wr_wait(8'h14, 32'hBBBB, 4);
    wr_wait(8'h14, 32'h4444, 4);
    wait_pulses(base + 2, 8 * SPAN);
    check(pulses == base + 2, "R9 prescaled run pulses", pulses, base + 2);
    wr_wait(8'h10, 32'd301, 3);
    wr_wait(8'h14, 32'hAAAA, 4);
    wr_wait(8'h14, 32'h5555, 4);
    repeat (6 * SPAN) @(negedge fclk);
    check(exp_q.size() == 0, "R8 all expected pulses seen", exp_q.size(), 0);
    check(pulses == base + 2, "R3 stopped after prescaled run", pulses, base + 2);

    done = 1'b1;
    finish_run();
  end
endmodule